// File: doc/BRIEF.md
# Flag-Setting Integer ALU with Shifter

This block is the integer execution unit of a 64-bit load/store core. Each cycle it combines two operands under a 3-bit operation code and drives the 64-bit result combinationally. It covers addition, subtraction, three bitwise operations and logical shifts in both directions. The shift count is taken from its own unsigned field, not from an operand.

The unit also holds the architectural condition flags: negative, zero, carry and overflow. The flag register changes only on a rising clock edge where three things are true: the operation is valid, the flag-setting variant is requested, and the operation is add, subtract or AND. Any other cycle leaves the flags untouched. A following branch unit reads the flags to evaluate conditions, including signed and unsigned comparisons after a subtract.

Top module: `alu_flag_unit`

## Requirements
- R1: With op_i=0 (add), result_o equals a_i + b_i modulo 2^64.
- R2: With op_i=1 (subtract), result_o equals a_i - b_i modulo 2^64, computed as a_i + ~b_i + 1.
- R3: With op_i=2, 3 and 4, result_o is the bitwise AND, inclusive OR and exclusive OR of a_i and b_i. An exclusive OR with b_i all ones yields ~a_i.
- R4: With op_i=5, result_o is a_i shifted left by shamt_i (0 to 63), with zeros filling the vacated low bits. A shamt_i of 0 returns a_i unchanged.
- R5: With op_i=6, result_o is a_i shifted right by shamt_i, with zeros filling the vacated high bits.
- R6: flags_o is {N, Z, C, V}, with bit 3 = N, bit 2 = Z, bit 1 = C and bit 0 = V. On a flag update, N takes bit 63 of the result, and Z is 1 exactly when the result is all zeros.
- R7: On a flag-setting add, C is the carry out of bit 63. V is 1 when both operands have the same sign and the result's sign differs from it.
- R8: On a flag-setting subtract, C is 1 exactly when no borrow occurs (a_i >= b_i unsigned). V is 1 when the operands differ in sign and the result's sign differs from a_i's sign.
- R9: A flag-setting AND clears C and V to 0.
- R10: The flags change only at a rising edge where valid_i=1, set_flags_i=1 and op_i is 0, 1 or 2. In every other cycle they keep their value, including when set_flags_i is 1 with any other operation.
- R11: An active-low asynchronous reset clears all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation is valid this cycle |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 shift left, 6 shift right) |
| set_flags_i | input | 1 | Request the flag-setting variant |
| a_i | input | 64 | First operand, also the value that is shifted |
| b_i | input | 64 | Second operand |
| shamt_i | input | 6 | Unsigned shift count |
| result_o | output | 64 | Combinational result |
| flags_o | output | 4 | Flag register {N, Z, C, V} |

## Verification
The bench builds the unit at its default width of 64 bits, which gives a 6-bit shift field. With that width the extreme shift counts 0 and 63 can be tested, as can a carry out of the top bit, a signed overflow at the 0x7FFF... and 0x8000... boundaries, and an all-ones complement through exclusive OR. Flag tests first set carry and overflow with an add, then issue a flag-setting AND, so the clearing can be seen. They also load a non-zero flag value before each hold case, so any unwanted write shows at the port.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_ORR = 3'd3,
    OP_XOR = 3'd4,
    OP_LSL = 3'd5,
    OP_LSR = 3'd6
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide;

  always_comb begin
    b_eff   = sub_i ? ~b_i : b_i;
    wide    = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
    sum_o   = wide[MSB:0];
    carry_o = wide[DATA_W];
    // same-sign inputs to the adder producing a different-sign sum
    ovf_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               left_i,
  output logic [DATA_W-1:0]  data_o
);
  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] rev_out;
  logic [DATA_W-1:0] stage [SHAMT_W+1];

  // left shift = reverse, shift right, reverse
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev_in[i] = data_i[DATA_W-1-i];
    assign rev_out[i] = stage[SHAMT_W][DATA_W-1-i];
  end

  assign stage[0] = left_i ? rev_in : data_i;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    assign stage[k+1] = shamt_i[k] ? (stage[k] >> (1 << k)) : stage[k];
  end

  assign data_o = left_i ? rev_out : stage[SHAMT_W];
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int unsigned FLAG_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [FLAG_W-1:0] d_i,
  output logic [FLAG_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [2:0]         op_i,
  input  logic               set_flags_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [DATA_W-1:0]  result_o,
  output logic [3:0]         flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  alu_op_e           op;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] shifted;
  logic              carry;
  logic              ovf;
  logic              flag_we;
  alu_flags_t        flags_d;

  assign op = alu_op_e'(op_i);

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (op == OP_SUB),
    .sum_o   (sum),
    .carry_o (carry),
    .ovf_o   (ovf)
  );

  alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shifter (
    .data_i  (a_i),
    .shamt_i (shamt_i),
    .left_i  (op == OP_LSL),
    .data_o  (shifted)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result_o = sum;
      OP_AND:         result_o = a_i & b_i;
      OP_ORR:         result_o = a_i | b_i;
      OP_XOR:         result_o = a_i ^ b_i;
      OP_LSL, OP_LSR: result_o = shifted;
      default:        result_o = '0;
    endcase
  end

  always_comb begin
    flags_d.n = result_o[MSB];
    flags_d.z = (result_o == '0);
    flags_d.c = (op == OP_AND) ? 1'b0 : carry;
    flags_d.v = (op == OP_AND) ? 1'b0 : ovf;
  end

  assign flag_we = valid_i && set_flags_i &&
                   (op == OP_ADD || op == OP_SUB || op == OP_AND);

  alu_flag_reg #(.FLAG_W(4)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (flag_we),
    .d_i    (flags_d),
    .q_o    (flags_o)
  );
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [2:0]         op_i,
  input logic               set_flags_i,
  input logic [DATA_W-1:0]  a_i,
  input logic [DATA_W-1:0]  b_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic [DATA_W-1:0]  result_o,
  input logic [3:0]         flags_o
);
  logic upd;
  assign upd = valid_i && set_flags_i && (op_i <= 3'd2);

  // R10
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> flags_o == $past(flags_o));

  // R6
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> flags_o[2] == ($past(result_o) == '0));

  // R6
  neg_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> flags_o[3] == $past(result_o[DATA_W-1]));

  // R9
  and_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && op_i == 3'd2) |=> flags_o[1:0] == 2'b00);

  // R4
  shift_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5 && shamt_i == '0) |-> result_o == a_i);

  // R3
  xor_not_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4 && b_i == '1) |-> result_o == ~a_i);
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (.*);

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;
  localparam int W = 64;
  localparam logic [63:0] ONES = '1;
  localparam logic [63:0] MSB1 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        valid = 0;
  logic [2:0]  op = 0;
  logic        sf = 0;
  logic [63:0] a = 0, b = 0;
  logic [5:0]  sh = 0;
  logic [63:0] res;
  logic [3:0]  flags;
  logic [3:0]  exp_flags = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alu_flag_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .set_flags_i(sf), .a_i(a), .b_i(b), .shamt_i(sh),
    .result_o(res), .flags_o(flags)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // bench flag model built from R6..R10
  function automatic logic [3:0] model_flags(logic [2:0] o, logic [63:0] x, logic [63:0] y);
    logic [64:0] w;
    logic [63:0] r;
    logic c, v;
    c = 0; v = 0;
    if (o == 3'd0) begin
      w = {1'b0, x} + {1'b0, y}; r = w[63:0]; c = w[64];
      v = (x[63] == y[63]) && (r[63] != x[63]);
    end else if (o == 3'd1) begin
      r = x - y; c = (x >= y);
      v = (x[63] != y[63]) && (r[63] != x[63]);
    end else r = x & y;
    return {r[63], r == 0, c, v};
  endfunction

  task automatic run(string req, logic [2:0] o, logic f, logic vl,
                     logic [63:0] x, logic [63:0] y, logic [5:0] s, logic [63:0] exp_res);
    @(negedge clk);
    op = o; sf = f; valid = vl; a = x; b = y; sh = s;
    #1 chk({req, " result"}, res, exp_res);
    if (vl && f && o <= 3'd2) exp_flags = model_flags(o, x, y);
    @(posedge clk);
    #1 chk({req, " flags"}, {60'd0, flags}, {60'd0, exp_flags});
  endtask

  task automatic t_reset;
    chk("R11 reset flags", {60'd0, flags}, 64'd0);
  endtask

  task automatic t_add;
    run("R1", 3'd0, 0, 1, 64'd5, 64'd7, 0, 64'd12);
    run("R1 R6", 3'd0, 1, 1, 64'd5, 64'd7, 0, 64'd12);
    chk("R6 flags add", {60'd0, flags}, 64'h0);
    run("R7 ovf", 3'd0, 1, 1, MAXP, 64'd1, 0, MSB1);
    chk("R7 NV", {60'd0, flags}, 64'b1001);
    run("R7 carry", 3'd0, 1, 1, ONES, 64'd1, 0, 64'd0);
    chk("R7 ZC", {60'd0, flags}, 64'b0110);
  endtask

  task automatic t_sub;
    run("R8 eq", 3'd1, 1, 1, 64'd3, 64'd3, 0, 64'd0);
    chk("R8 ZC", {60'd0, flags}, 64'b0110);
    run("R2 R8 borrow", 3'd1, 1, 1, 64'd1, 64'd2, 0, ONES);
    chk("R8 N", {60'd0, flags}, 64'b1000);
    run("R8 ovf", 3'd1, 1, 1, MSB1, 64'd1, 0, MAXP);
    chk("R8 CV", {60'd0, flags}, 64'b0011);
  endtask

  task automatic t_logic;
    run("R3 and", 3'd2, 0, 1, 64'h0DC0, 64'h3C00, 0, 64'h0C00);
    run("R3 orr", 3'd3, 0, 1, 64'h0DC0, 64'h3C00, 0, 64'h3DC0);
    run("R3 xor", 3'd4, 0, 1, 64'hF0F0, 64'h0FF0, 0, 64'hFF00);
    run("R3 not", 3'd4, 0, 1, 64'h0DC0, ONES, 0, ~64'h0DC0);
  endtask

  task automatic t_and_flags;
    run("R9 prep", 3'd0, 1, 1, ONES, MSB1, 0, MAXP);
    chk("R9 prep CV", {60'd0, flags}, 64'b0011);
    run("R9 ands", 3'd2, 1, 1, ONES, MSB1, 0, MSB1);
    chk("R9 cleared", {60'd0, flags}, 64'b1000);
  endtask

  task automatic t_shift;
    run("R4 lsl 63", 3'd5, 0, 1, 64'd1, 0, 6'd63, MSB1);
    run("R4 lsl 0", 3'd5, 0, 1, 64'h1234, 0, 6'd0, 64'h1234);
    run("R4 lsl 4", 3'd5, 0, 1, ONES, 0, 6'd4, 64'hFFFF_FFFF_FFFF_FFF0);
    run("R5 lsr 63", 3'd6, 0, 1, ONES, 0, 6'd63, 64'd1);
    run("R5 lsr 8", 3'd6, 0, 1, MSB1, 0, 6'd8, 64'h0080_0000_0000_0000);
  endtask

  task automatic t_hold;
    run("R10 prep", 3'd1, 1, 1, 64'd1, 64'd2, 0, ONES);
    run("R10 sf off", 3'd0, 0, 1, 64'd0, 64'd0, 0, 64'd0);
    run("R10 invalid", 3'd0, 1, 0, 64'd0, 64'd0, 0, 64'd0);
    run("R10 orr sf", 3'd3, 1, 1, 64'd0, 64'd0, 0, 64'd0);
    run("R10 lsl sf", 3'd5, 1, 1, 64'd0, 0, 6'd1, 64'd0);
    chk("R10 kept", {60'd0, flags}, 64'b1000);
  endtask

  initial begin
    #12 t_reset;
    rst_n = 1;
    t_add;
    t_sub;
    t_logic;
    t_and_flags;
    t_shift;
    t_hold;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule